// File: doc/BRIEF.md
# Channel Event Interrupt Descriptor Generator

This block converts transfer events and errors reported by per-channel logic into 32-bit interrupt descriptor words and pushes them toward an interrupt queue. Each incoming event carries a direction (transmit or receive), a channel number, a 7-bit event code and an error flag. An enable register, one bit per event code, decides which events are reported. The descriptor leaves through a valid/ready push port. A queue writer or a FIFO sits on the other side.

When an end-of-message event arrives together with an end-of-buffer event, direction-dependent rules apply. On the receive side the two merge into a single descriptor. End-of-message normally wins. End-of-buffer is reported only when end-of-message is disabled and end-of-buffer is enabled. On the transmit side both are reported as two descriptors, end-of-buffer first.

Back-pressure rules: `desc_valid` stays high, and `desc_data` stays unchanged, until the consumer raises `desc_ready`. A descriptor is transferred on every clock edge where both are high. While the consumer stalls, a pending buffer holds up to `PEND_DEPTH` descriptors. A descriptor that finds no room is dropped, and a sticky overflow flag records the loss. Event inputs have no ready signal: the producer presents one event per cycle and never waits.

Top module: `irq_desc_gen`

## Requirements
- R1: A valid event whose code is enabled produces exactly one descriptor (except the coincident cases of R3 to R6). A valid event whose code is disabled produces none.
- R2: Descriptor layout:
  - bit 31 is the direction (1 = transmit, 0 = receive);
  - bits 30:24 are the event code;
  - bit 23 is the error flag;
  - bits 11:0 are the channel number;
  - bits 22:12 are zero.
- R3: On receive, an event with code 2 (end-of-message) and `evt_eob_too` set, with code 2 enabled, yields only one descriptor. That descriptor has code 2 and carries `evt_err`.
- R4: On receive, in the coincident case with code 2 disabled and code 1 (end-of-buffer) enabled, only a code 1 descriptor is produced, with its error bit 0. With both codes disabled, nothing is produced.
- R5: The receive merge rules of R3 and R4 apply unchanged when `evt_err` is 1.
- R6: On transmit, in the coincident case, each enabled code among 1 and 2 produces its own descriptor. When both are enabled, code 1 is delivered before code 2. Only the code 2 descriptor carries `evt_err`.
- R7: While `desc_valid` is 1 and `desc_ready` is 0, `desc_valid` stays 1 and `desc_data` stays unchanged. Descriptors leave in the order they were generated.
- R8: At most `PEND_DEPTH` (default 4) descriptors are pending. A descriptor that would exceed this limit is dropped, and `overflow` becomes 1. It stays 1 until reset.
- R9: Reset does three things: it empties the pending buffer, clears `overflow`, and enables all codes. A `cfg_we` pulse loads `cfg_enable`, where bit k set enables code k. Codes of `NUM_CODES` and above are always reported. `evt_eob_too` is ignored unless the code is 2.
- R10: With the pending buffer empty, the descriptor for an event appears on `desc_valid`/`desc_data` one clock edge after the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load the enable register |
| cfg_enable | input | NUM_CODES | Per-code enable bits, 1 = report |
| evt_valid | input | 1 | Event present this cycle |
| evt_tx | input | 1 | Direction, 1 = transmit |
| evt_chan | input | 12 | Channel number |
| evt_code | input | 7 | Event code |
| evt_err | input | 1 | Event is an error |
| evt_eob_too | input | 1 | End-of-buffer coincides with this end-of-message |
| desc_valid | output | 1 | Descriptor available |
| desc_ready | input | 1 | Consumer accepts descriptor |
| desc_data | output | 32 | Descriptor word |
| overflow | output | 1 | Sticky: a descriptor was dropped |

## Verification
The assertions check the following on every cycle:
- the output holds its value under back-pressure;
- the reserved descriptor bits are zero;
- a receive event never requests more than one descriptor;
- the pending count stays within its bound, and overflow is sticky;
- an event arriving at an empty buffer appears on the next cycle.

Only the directed scenarios can show which code wins each coincident merge, how masking interacts with merging, the transmit ordering, the exact field contents, and which descriptors survive an overflow.

// File: rtl/idg_pkg.sv
package idg_pkg;
  localparam int CODE_W = 7;
  localparam int CHAN_W = 12;
  localparam int DESC_W = 32;
  localparam logic [CODE_W-1:0] CODE_EOB = 7'd1;
  localparam logic [CODE_W-1:0] CODE_EOM = 7'd2;

  // Build one descriptor word; reserved bits 22:12 are zero.
  function automatic logic [DESC_W-1:0] pack_desc(input logic tx,
                                                  input logic [CODE_W-1:0] code,
                                                  input logic err,
                                                  input logic [CHAN_W-1:0] chan);
    pack_desc = {tx, code, err, 11'd0, chan};
  endfunction
endpackage

// File: rtl/idg_mask_reg.sv
module idg_mask_reg #(
  parameter int NUM_CODES = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [NUM_CODES-1:0] wdata,
  output logic [NUM_CODES-1:0] enable
);
  always_ff @(posedge clk) begin
    if (!rst_n)   enable <= '1;
    else if (we)  enable <= wdata;
  end
endmodule

// File: rtl/idg_merge.sv
module idg_merge
  import idg_pkg::*;
#(
  parameter int NUM_CODES = 16
) (
  input  logic                 evt_valid,
  input  logic                 evt_tx,
  input  logic [CHAN_W-1:0]    evt_chan,
  input  logic [CODE_W-1:0]    evt_code,
  input  logic                 evt_err,
  input  logic                 evt_eob_too,
  input  logic [NUM_CODES-1:0] enable,
  output logic [1:0]           n_req,
  output logic [DESC_W-1:0]    d0,
  output logic [DESC_W-1:0]    d1
);
  localparam int IW = (NUM_CODES > 1) ? $clog2(NUM_CODES) : 1;

  function automatic logic code_on(input logic [CODE_W-1:0] c);
    if (int'(c) >= NUM_CODES) return 1'b1;
    return enable[c[IW-1:0]];
  endfunction

  logic coinc, on_code, on_eob, on_eom;
  logic [DESC_W-1:0] w_eob, w_eom, w_any;

  assign coinc   = (evt_code == CODE_EOM) && evt_eob_too;
  assign on_code = code_on(evt_code);
  assign on_eob  = code_on(CODE_EOB);
  assign on_eom  = code_on(CODE_EOM);
  assign w_eob   = pack_desc(evt_tx, CODE_EOB, 1'b0, evt_chan);
  assign w_eom   = pack_desc(evt_tx, CODE_EOM, evt_err, evt_chan);
  assign w_any   = pack_desc(evt_tx, evt_code, evt_err, evt_chan);

  always_comb begin
    n_req = 2'd0;
    d0    = '0;
    d1    = '0;
    if (evt_valid) begin
      if (coinc && !evt_tx) begin
        // receive: one descriptor, end-of-message has priority
        if (on_eom) begin
          n_req = 2'd1; d0 = w_eom;
        end else if (on_eob) begin
          n_req = 2'd1; d0 = w_eob;
        end
      end else if (coinc) begin
        // transmit: independent, end-of-buffer first
        if (on_eob && on_eom) begin
          n_req = 2'd2; d0 = w_eob; d1 = w_eom;
        end else if (on_eob) begin
          n_req = 2'd1; d0 = w_eob;
        end else if (on_eom) begin
          n_req = 2'd1; d0 = w_eom;
        end
      end else if (on_code) begin
        n_req = 2'd1; d0 = w_any;
      end
    end
  end
endmodule

// File: rtl/idg_pend_fifo.sv
module idg_pend_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   n_req,
  input  logic [W-1:0] d0,
  input  logic [W-1:0] d1,
  input  logic         pop,
  output logic         head_valid,
  output logic [W-1:0] head,
  output logic         drop,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [PW-1:0] wptr, rptr, wptr1;
  logic [CW:0]   free_w;
  logic [1:0]    n_acc;
  logic [W-1:0]  slots [DEPTH];

  assign wptr1 = wptr + PW'(1);

  always_comb begin
    free_w = (CW+1)'(DEPTH) - {1'b0, count};
    if (free_w >= (CW+1)'(n_req)) n_acc = n_req;
    else                          n_acc = free_w[1:0];
  end
  assign drop = (n_acc != n_req);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [W-1:0] q;
    always_ff @(posedge clk) begin
      if (n_acc != 2'd0 && wptr == PW'(i))       q <= d0;
      else if (n_acc == 2'd2 && wptr1 == PW'(i)) q <= d1;
    end
    assign slots[i] = q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      wptr  <= wptr + PW'(n_acc);
      if (pop) rptr <= rptr + PW'(1);
      count <= count + CW'(n_acc) - CW'(pop);
    end
  end

  assign head_valid = (count != '0);
  assign head       = slots[rptr];
endmodule

// File: rtl/irq_desc_gen.sv
module irq_desc_gen
  import idg_pkg::*;
#(
  parameter int NUM_CODES  = 16,
  parameter int PEND_DEPTH = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [NUM_CODES-1:0] cfg_enable,
  input  logic                 evt_valid,
  input  logic                 evt_tx,
  input  logic [11:0]          evt_chan,
  input  logic [6:0]           evt_code,
  input  logic                 evt_err,
  input  logic                 evt_eob_too,
  output logic                 desc_valid,
  input  logic                 desc_ready,
  output logic [31:0]          desc_data,
  output logic                 overflow
);
  localparam int CW = $clog2(PEND_DEPTH+1);

  logic [NUM_CODES-1:0] enable;
  logic [1:0]           n_req;
  logic [DESC_W-1:0]    d0, d1;
  logic                 drop;
  logic [CW-1:0]        pend_count;

  idg_mask_reg #(.NUM_CODES(NUM_CODES)) mask_i (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_enable), .enable(enable)
  );

  idg_merge #(.NUM_CODES(NUM_CODES)) merge_i (
    .evt_valid(evt_valid), .evt_tx(evt_tx), .evt_chan(evt_chan),
    .evt_code(evt_code), .evt_err(evt_err), .evt_eob_too(evt_eob_too),
    .enable(enable), .n_req(n_req), .d0(d0), .d1(d1)
  );

  idg_pend_fifo #(.DEPTH(PEND_DEPTH), .W(DESC_W)) fifo_i (
    .clk(clk), .rst_n(rst_n), .n_req(n_req), .d0(d0), .d1(d1),
    .pop(desc_valid && desc_ready), .head_valid(desc_valid),
    .head(desc_data), .drop(drop), .count(pend_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)    overflow <= 1'b0;
    else if (drop) overflow <= 1'b1;
  end
endmodule

// File: rtl/irq_desc_gen_chk.sv
module irq_desc_gen_chk #(
  parameter int PEND_DEPTH = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        evt_valid,
  input logic        evt_tx,
  input logic        desc_valid,
  input logic        desc_ready,
  input logic [31:0] desc_data,
  input logic        overflow,
  input logic [1:0]  n_req,
  input logic [$clog2(PEND_DEPTH+1)-1:0] pend_count
);
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && !desc_ready |=> desc_valid && $stable(desc_data));

  assert_layout_R2: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> desc_data[22:12] == 11'd0);

  assert_rx_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid && !evt_tx |-> n_req <= 2'd1);

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  assert_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pend_count) <= PEND_DEPTH);

  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    n_req != 2'd0 && pend_count == '0 |=> desc_valid);
endmodule

bind irq_desc_gen irq_desc_gen_chk #(.PEND_DEPTH(PEND_DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_tx(evt_tx),
  .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_data(desc_data),
  .overflow(overflow), .n_req(n_req), .pend_count(pend_count)
);

// File: tb/irq_desc_gen_tb_top.sv
module irq_desc_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_enable = '1;
  logic        evt_valid = 1'b0, evt_tx = 1'b0, evt_err = 1'b0, evt_eob_too = 1'b0;
  logic [11:0] evt_chan = '0;
  logic [6:0]  evt_code = '0;
  logic        desc_valid, desc_ready, overflow;
  logic [31:0] desc_data;

  int n_chk = 0, n_fail = 0, ncap = 0;
  logic [31:0] cap [64];
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  irq_desc_gen dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_enable(cfg_enable),
    .evt_valid(evt_valid), .evt_tx(evt_tx), .evt_chan(evt_chan),
    .evt_code(evt_code), .evt_err(evt_err), .evt_eob_too(evt_eob_too),
    .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_data(desc_data),
    .overflow(overflow)
  );

  always @(posedge clk)
    if (rst_n && desc_valid && desc_ready && ncap < 64) begin
      cap[ncap] <= desc_data;
      ncap <= ncap + 1;
    end

  function automatic logic [31:0] exp_d(input logic tx, input logic [6:0] c,
                                        input logic e, input logic [11:0] ch);
    return {tx, c, e, 11'd0, ch};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic send(input logic tx, input logic [11:0] ch, input logic [6:0] c,
                      input logic e, input logic both);
    @(negedge clk);
    evt_valid = 1'b1; evt_tx = tx; evt_chan = ch; evt_code = c;
    evt_err = e; evt_eob_too = both;
    @(negedge clk);
    evt_valid = 1'b0; evt_eob_too = 1'b0; evt_err = 1'b0;
  endtask

  task automatic set_en(input logic [15:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_enable = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  // expect exactly the listed descriptors since base
  task automatic expect_n(input int base, input int n, input logic [31:0] a,
                          input logic [31:0] b, input string req);
    check(ncap - base == n, req, 32'(ncap - base), 32'(n));
    if (n >= 1 && ncap - base >= 1) check(cap[base] == a, req, cap[base], a);
    if (n >= 2 && ncap - base >= 2) check(cap[base+1] == b, req, cap[base+1], b);
  endtask

  task automatic t_reset();
    check(desc_valid == 1'b0, "R9 reset valid", 32'(desc_valid), 0);
    check(overflow == 1'b0, "R9 reset overflow", 32'(overflow), 0);
  endtask

  task automatic t_latency_hold();
    logic [31:0] e;
    int base;
    desc_ready = 1'b0;
    e = exp_d(1'b0, 7'd5, 1'b0, 12'h123);
    @(negedge clk);
    evt_valid = 1'b1; evt_tx = 1'b0; evt_chan = 12'h123; evt_code = 7'd5;
    @(negedge clk);
    evt_valid = 1'b0;
    check(desc_valid == 1'b1 && desc_data == e, "R10 latency", desc_data, e);
    repeat (3) @(negedge clk);
    check(desc_valid == 1'b1 && desc_data == e, "R7 hold", desc_data, e);
    base = ncap;
    desc_ready = 1'b1;
    @(negedge clk);
    check(desc_valid == 1'b0, "R7 drained", 32'(desc_valid), 0);
    expect_n(base, 1, e, 0, "R1 single");
  endtask

  task automatic t_mask();
    int base = ncap;
    set_en(16'hFFDF);
    send(1'b0, 12'h010, 7'd5, 1'b0, 1'b0);
    settle();
    expect_n(base, 0, 0, 0, "R1 masked");
    base = ncap;
    send(1'b0, 12'h011, 7'd6, 1'b0, 1'b0);
    settle();
    expect_n(base, 1, exp_d(1'b0, 7'd6, 1'b0, 12'h011), 0, "R1 enabled");
    set_en(16'hFFFF);
  endtask

  task automatic t_layout();
    int base = ncap;
    send(1'b1, 12'hFFF, 7'd9, 1'b1, 1'b0);
    settle();
    expect_n(base, 1, 32'h8980_0FFF, 0, "R2 layout");
  endtask

  task automatic t_rx_merge();
    int base = ncap;
    send(1'b0, 12'h020, 7'd2, 1'b0, 1'b1);
    settle();
    expect_n(base, 1, exp_d(1'b0, 7'd2, 1'b0, 12'h020), 0, "R3 rx eom wins");
    base = ncap;
    send(1'b0, 12'h021, 7'd2, 1'b1, 1'b1);
    settle();
    expect_n(base, 1, exp_d(1'b0, 7'd2, 1'b1, 12'h021), 0, "R5 rx err eom");
    set_en(16'hFFFB);
    base = ncap;
    send(1'b0, 12'h022, 7'd2, 1'b0, 1'b1);
    settle();
    expect_n(base, 1, exp_d(1'b0, 7'd1, 1'b0, 12'h022), 0, "R4 rx eob");
    base = ncap;
    send(1'b0, 12'h023, 7'd2, 1'b1, 1'b1);
    settle();
    expect_n(base, 1, exp_d(1'b0, 7'd1, 1'b0, 12'h023), 0, "R5 rx err eob");
    set_en(16'hFFF9);
    base = ncap;
    send(1'b0, 12'h024, 7'd2, 1'b0, 1'b1);
    settle();
    expect_n(base, 0, 0, 0, "R4 both masked");
    set_en(16'hFFFF);
  endtask

  task automatic t_tx_merge();
    int base = ncap;
    send(1'b1, 12'h030, 7'd2, 1'b1, 1'b1);
    settle();
    expect_n(base, 2, exp_d(1'b1, 7'd1, 1'b0, 12'h030),
             exp_d(1'b1, 7'd2, 1'b1, 12'h030), "R6 tx both");
    set_en(16'hFFFD);
    base = ncap;
    send(1'b1, 12'h031, 7'd2, 1'b0, 1'b1);
    settle();
    expect_n(base, 1, exp_d(1'b1, 7'd2, 1'b0, 12'h031), 0, "R6 tx eob masked");
    set_en(16'hFFFF);
  endtask

  task automatic t_misc();
    int base = ncap;
    set_en(16'h0000);
    send(1'b0, 12'h040, 7'h40, 1'b0, 1'b0);
    settle();
    expect_n(base, 1, exp_d(1'b0, 7'h40, 1'b0, 12'h040), 0, "R9 high code");
    set_en(16'hFFFF);
    base = ncap;
    send(1'b0, 12'h041, 7'd5, 1'b0, 1'b1);
    settle();
    expect_n(base, 1, exp_d(1'b0, 7'd5, 1'b0, 12'h041), 0, "R9 flag ignored");
  endtask

  task automatic t_overflow();
    int base;
    desc_ready = 1'b0;
    for (int i = 1; i <= 4; i++) send(1'b0, 12'(i), 7'd7, 1'b0, 1'b0);
    check(overflow == 1'b0, "R8 no overflow at 4", 32'(overflow), 0);
    send(1'b0, 12'd5, 7'd7, 1'b0, 1'b0);
    check(overflow == 1'b1, "R8 overflow set", 32'(overflow), 1);
    base = ncap;
    desc_ready = 1'b1;
    settle();
    check(ncap - base == 4, "R8 kept four", 32'(ncap - base), 4);
    for (int i = 0; i < 4; i++)
      if (ncap - base > i)
        check(cap[base+i] == exp_d(1'b0, 7'd7, 1'b0, 12'(i+1)), "R8 order",
              cap[base+i], exp_d(1'b0, 7'd7, 1'b0, 12'(i+1)));
    check(overflow == 1'b1, "R8 sticky", 32'(overflow), 1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check(overflow == 1'b0, "R9 reset clears", 32'(overflow), 0);
  endtask

  initial begin
    desc_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_latency_hold();
    t_mask();
    t_layout();
    t_rx_merge();
    t_tx_merge();
    t_misc();
    t_overflow();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule